// File: doc/BRIEF.md
# Non-PCM Burst Preamble Detector

This block sits behind a biphase receiver and inspects the 16-bit audio words it produces, one per subframe, qualified by a word-valid strobe. It searches the word stream for the preamble that opens a compressed-audio burst. The preamble is four all-zero words followed by the two sync words 0xF872 and 0x4E1F. The block also searches for the 32-bit DTS-CD sync word. When it finds the burst preamble, it takes the next two valid words as the burst info word and the length code, and holds them on its outputs.

Each kind of sync raises its own status flag. A flag stays up while syncs keep arriving, and it drops once a programmable number of frame strobes pass with no new sync of that kind. A combined flag is the OR of the two status flags. A one-clock pulse marks every change of the combined flag, so downstream logic can mute or unmute without polling.

Top module: `nonpcm_detect`

## Requirements
- R1: After reset, the burst flag rises at the clock edge that samples a valid 0x4E1F word directly preceded (among valid words) by 0x0000, 0x0000, 0x0000, 0x0000, 0xF872.
- R2: Any valid word that breaks the preamble sequence restarts the search. A 0x0000 breaking word counts as the first zero of a new attempt, and any other breaking word counts as no zero. So five zeros followed by 0xF872, 0x4E1F is not a match.
- R3: The first and second valid words after a matched preamble are loaded into burst_info (Pc; bits 4:0 data type, bit 7 payload-error flag) and burst_len (Pd, length in bits). Each is loaded at the edge that samples its word, and both hold until the next burst overwrites them.
- R4: The burst flag falls at the edge that samples the TIMEOUT_FRAMES-th frame strobe after its last preamble match. Every new match restarts this count from zero.
- R5: The DTS flag rises at the edge that samples a valid 0x8001 word directly after a valid 0x7FFE word. It times out the same way as R4, on its own counter.
- R6: auto_flag always equals the OR of the burst flag and the DTS flag.
- R7: When auto_flag falls, burst_info and burst_len are zero on that same cycle.
- R8: auto_change is high for exactly one clock on each cycle in which auto_flag differs from its previous value, on both rising and falling changes.
- R9: A word presented with word_valid low neither advances nor breaks either sync search, and it is never loaded as Pc or Pd.
- R10: Reset (synchronous, active high) clears all flags, the pulse, burst_info and burst_len.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| word_valid | input | 1 | word_data holds a decoded subframe word this cycle |
| word_data | input | 16 | Decoded 16-bit audio word |
| frame_tick | input | 1 | One-cycle strobe per received frame |
| npcm_flag | output | 1 | Burst preamble seen recently |
| dts_flag | output | 1 | DTS-CD sync seen recently |
| auto_flag | output | 1 | OR of npcm_flag and dts_flag |
| auto_change | output | 1 | One-clock pulse on any change of auto_flag |
| burst_info | output | 16 | Last captured burst info word (Pc) |
| burst_len | output | 16 | Last captured length code (Pd) |

## Verification
The bench builds the block with TIMEOUT_FRAMES set to 16 in place of 4096. This makes expiry, restart of the count by a fresh match, and staggered expiry of the two flags reachable in a few dozen frame strobes. It makes the exact expiry edge visible at the 16th strobe. The short window also makes it cheap to cover the case where the DTS flag lapses while the burst flag holds auto_flag high, which has to keep Pc and Pd. Other runs cover preamble attempts broken by a zero and by a non-zero word, and invalid words placed inside a preamble.

// File: rtl/nonpcm_detect_pkg.sv
package nonpcm_detect_pkg;

  localparam int WORD_W = 16;

  localparam logic [WORD_W-1:0] ZERO_WORD  = 16'h0000;
  localparam logic [WORD_W-1:0] SYNC_A     = 16'hF872;
  localparam logic [WORD_W-1:0] SYNC_B     = 16'h4E1F;
  localparam logic [WORD_W-1:0] DTS_HI     = 16'h7FFE;
  localparam logic [WORD_W-1:0] DTS_LO     = 16'h8001;

  // number of independent sync sources (burst, dts)
  localparam int NUM_SRC = 2;
  localparam int SRC_BURST = 0;
  localparam int SRC_DTS   = 1;

  typedef enum logic [2:0] {
    ST_Z0, ST_Z1, ST_Z2, ST_Z3,  // n leading zeros matched
    ST_SA,                        // four zeros matched, expect SYNC_A
    ST_SB,                        // expect SYNC_B
    ST_PC,                        // next valid word is burst info
    ST_PD                         // next valid word is length code
  } burst_st_t;

endpackage

// File: rtl/nonpcm_burst_match.sv
module nonpcm_burst_match
  import nonpcm_detect_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              sync_hit,
  output logic              pc_stb,
  output logic              pd_stb
);

  burst_st_t st_q, st_n;
  logic      is_zero;

  assign is_zero  = (word_data == ZERO_WORD);
  assign sync_hit = word_valid && (st_q == ST_SB) && (word_data == SYNC_B);
  assign pc_stb   = word_valid && (st_q == ST_PC);
  assign pd_stb   = word_valid && (st_q == ST_PD);

  always_comb begin
    st_n = st_q;
    if (word_valid) begin
      unique case (st_q)
        ST_Z0:   st_n = is_zero ? ST_Z1 : ST_Z0;
        ST_Z1:   st_n = is_zero ? ST_Z2 : ST_Z0;
        ST_Z2:   st_n = is_zero ? ST_Z3 : ST_Z0;
        ST_Z3:   st_n = is_zero ? ST_SA : ST_Z0;
        ST_SA:   st_n = (word_data == SYNC_A) ? ST_SB : (is_zero ? ST_Z1 : ST_Z0);
        ST_SB:   st_n = (word_data == SYNC_B) ? ST_PC : (is_zero ? ST_Z1 : ST_Z0);
        ST_PC:   st_n = ST_PD;
        ST_PD:   st_n = ST_Z0;
        default: st_n = ST_Z0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_Z0;
    else     st_q <= st_n;
  end

endmodule

// File: rtl/nonpcm_dts_match.sv
module nonpcm_dts_match
  import nonpcm_detect_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              sync_hit
);

  logic hi_seen_q;

  assign sync_hit = word_valid && hi_seen_q && (word_data == DTS_LO);

  always_ff @(posedge clk) begin
    if (rst)             hi_seen_q <= 1'b0;
    else if (word_valid) hi_seen_q <= (word_data == DTS_HI);
  end

endmodule

// File: rtl/nonpcm_hold_timer.sv
module nonpcm_hold_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_hit,
  input  logic frame_tick,
  output logic flag_q,
  output logic flag_n
);

  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n  = cnt_q;
    flag_n = flag_q;
    if (sync_hit) begin
      flag_n = 1'b1;
      cnt_n  = '0;
    end else if (frame_tick && flag_q) begin
      if (cnt_q == LAST) begin
        flag_n = 1'b0;
        cnt_n  = '0;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      flag_q <= flag_n;
      cnt_q  <= cnt_n;
    end
  end

endmodule

// File: rtl/nonpcm_detect.sv
module nonpcm_detect
  import nonpcm_detect_pkg::*;
#(
  parameter int TIMEOUT_FRAMES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  input  logic              frame_tick,
  output logic              npcm_flag,
  output logic              dts_flag,
  output logic              auto_flag,
  output logic              auto_change,
  output logic [WORD_W-1:0] burst_info,
  output logic [WORD_W-1:0] burst_len
);

  logic               burst_hit, dts_hit, pc_stb, pd_stb;
  logic [NUM_SRC-1:0] hit_v, flag_q_v, flag_n_v;
  logic               auto_q, auto_n, chg_q;
  logic [WORD_W-1:0]  pc_q, pd_q;

  nonpcm_burst_match u_burst (
    .clk        (clk),
    .rst        (rst),
    .word_valid (word_valid),
    .word_data  (word_data),
    .sync_hit   (burst_hit),
    .pc_stb     (pc_stb),
    .pd_stb     (pd_stb)
  );

  nonpcm_dts_match u_dts (
    .clk        (clk),
    .rst        (rst),
    .word_valid (word_valid),
    .word_data  (word_data),
    .sync_hit   (dts_hit)
  );

  always_comb begin
    hit_v            = '0;
    hit_v[SRC_BURST] = burst_hit;
    hit_v[SRC_DTS]   = dts_hit;
  end

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_hold
    nonpcm_hold_timer #(.LIMIT(TIMEOUT_FRAMES)) u_timer (
      .clk        (clk),
      .rst        (rst),
      .sync_hit   (hit_v[gi]),
      .frame_tick (frame_tick),
      .flag_q     (flag_q_v[gi]),
      .flag_n     (flag_n_v[gi])
    );
  end

  assign auto_n = |flag_n_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      auto_q <= 1'b0;
      chg_q  <= 1'b0;
      pc_q   <= '0;
      pd_q   <= '0;
    end else begin
      auto_q <= auto_n;
      chg_q  <= (auto_n != auto_q);
      if (auto_q && !auto_n) begin
        pc_q <= '0;
        pd_q <= '0;
      end else begin
        if (pc_stb) pc_q <= word_data;
        if (pd_stb) pd_q <= word_data;
      end
    end
  end

  assign npcm_flag   = flag_q_v[SRC_BURST];
  assign dts_flag    = flag_q_v[SRC_DTS];
  assign auto_flag   = auto_q;
  assign auto_change = chg_q;
  assign burst_info  = pc_q;
  assign burst_len   = pd_q;

endmodule

// File: rtl/nonpcm_detect_sva.sv
module nonpcm_detect_sva
  import nonpcm_detect_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              word_valid,
  input logic [WORD_W-1:0] word_data,
  input logic              frame_tick,
  input logic              npcm_flag,
  input logic              dts_flag,
  input logic              auto_flag,
  input logic              auto_change,
  input logic [WORD_W-1:0] burst_info,
  input logic [WORD_W-1:0] burst_len
);

  p_auto_or_r6: assert property (@(posedge clk) disable iff (rst)
    auto_flag == (npcm_flag | dts_flag));

  p_change_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    auto_change == (auto_flag != $past(auto_flag)));

  p_clear_on_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(auto_flag) |-> (burst_info == '0 && burst_len == '0));

  p_burst_rise_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(npcm_flag) |-> $past(word_valid && word_data == SYNC_B));

  p_dts_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(dts_flag) |-> $past(word_valid && word_data == DTS_LO));

  p_expire_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(npcm_flag) || $fell(dts_flag)) |-> $past(frame_tick));

  p_info_source_r3: assert property (@(posedge clk) disable iff (rst)
    !$stable(burst_info) |-> ($past(word_valid) || !auto_flag));

endmodule

bind nonpcm_detect nonpcm_detect_sva u_sva (.*);

// File: tb/nonpcm_detect_bench.sv
module nonpcm_detect_bench;

  localparam int TO = 16;

  typedef struct {
    logic        npcm;
    logic        dts;
    logic        au;
    logic        chg;
    logic [15:0] pc;
    logic [15:0] pd;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_valid = 1'b0;
  logic [15:0] word_data = 16'h0;
  logic        frame_tick = 1'b0;
  logic        npcm_flag, dts_flag, auto_flag, auto_change;
  logic [15:0] burst_info, burst_len;

  int checks = 0;
  int failures = 0;
  exp_t q[$];

  logic        e_npcm = 0, e_dts = 0, e_auto = 0;
  logic [15:0] e_pc = 0, e_pd = 0;

  always #5 clk = ~clk;

  nonpcm_detect #(.TIMEOUT_FRAMES(TO)) u_nonpcm_detect (
    .clk(clk), .rst(rst), .word_valid(word_valid), .word_data(word_data),
    .frame_tick(frame_tick), .npcm_flag(npcm_flag), .dts_flag(dts_flag),
    .auto_flag(auto_flag), .auto_change(auto_change),
    .burst_info(burst_info), .burst_len(burst_len)
  );

  // driver: applies one cycle of stimulus and queues the expected outputs
  task automatic put(input logic v, input logic [15:0] d, input logic t, input string tag);
    exp_t it;
    logic na;
    @(negedge clk);
    word_valid = v; word_data = d; frame_tick = t;
    na = e_npcm | e_dts;
    if (e_auto && !na) begin e_pc = 16'h0; e_pd = 16'h0; end
    it.npcm = e_npcm; it.dts = e_dts; it.au = na; it.chg = (na != e_auto);
    it.pc = e_pc; it.pd = e_pd; it.tag = tag;
    e_auto = na;
    q.push_back(it);
  endtask

  task automatic wr(input logic [15:0] d, input string tag);
    put(1'b1, d, 1'b0, tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) put(1'b0, 16'h0, 1'b1, tag);
  endtask

  task automatic zeros(input int n, input string tag);
    for (int i = 0; i < n; i++) wr(16'h0000, tag);
  endtask

  // monitor: compares outputs one step after each driven cycle
  initial begin
    exp_t it;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (npcm_flag !== it.npcm || dts_flag !== it.dts || auto_flag !== it.au ||
            auto_change !== it.chg || burst_info !== it.pc || burst_len !== it.pd) begin
          failures++;
          $display("FAIL %s actual n=%b d=%b a=%b c=%b pc=%h pd=%h expected n=%b d=%b a=%b c=%b pc=%h pd=%h",
                   it.tag, npcm_flag, dts_flag, auto_flag, auto_change, burst_info, burst_len,
                   it.npcm, it.dts, it.au, it.chg, it.pc, it.pd);
        end
      end
    end
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    checks++;
    if (npcm_flag !== 0 || dts_flag !== 0 || auto_flag !== 0 || auto_change !== 0 ||
        burst_info !== 0 || burst_len !== 0) begin
      failures++;
      $display("FAIL R10 actual n=%b d=%b a=%b c=%b pc=%h pd=%h expected all zero",
               npcm_flag, dts_flag, auto_flag, auto_change, burst_info, burst_len);
    end

    // R1/R3/R8: clean preamble then Pc/Pd
    zeros(4, "R1 zeros");
    wr(16'hF872, "R1 sync A");
    e_npcm = 1; wr(16'h4E1F, "R1 R8 sync B");
    e_pc = 16'h0081; wr(16'h0081, "R3 Pc");
    e_pd = 16'h1800; wr(16'h1800, "R3 Pd");

    // R4/R7/R8: expiry on the TO-th frame strobe
    ticks(TO - 1, "R4 hold");
    e_npcm = 0; put(1'b0, 16'h0, 1'b1, "R4 R7 R8 expire");

    // R2: attempt broken by non-zero word, then full match
    zeros(3, "R2 partial");
    wr(16'h0005, "R2 break");
    zeros(4, "R2 zeros");
    wr(16'hF872, "R2 sync A");
    e_npcm = 1; wr(16'h4E1F, "R2 sync B");
    e_pc = 16'h0001; wr(16'h0001, "R3 Pc");
    e_pd = 16'h0600; wr(16'h0600, "R3 Pd");

    // R4 reload and R9 invalid word inside the preamble
    ticks(10, "R4 partial");
    zeros(4, "R9 zeros");
    wr(16'hF872, "R9 sync A");
    put(1'b0, 16'h1234, 1'b0, "R9 invalid word");
    wr(16'h4E1F, "R9 sync B");
    put(1'b0, 16'h7777, 1'b0, "R9 invalid not Pc");
    e_pc = 16'h000B; wr(16'h000B, "R3 R9 Pc");
    e_pd = 16'h2000; wr(16'h2000, "R3 Pd");
    ticks(TO - 1, "R4 reloaded hold");
    e_npcm = 0; put(1'b0, 16'h0, 1'b1, "R4 R7 expire");

    // R2: five zeros do not form a preamble
    zeros(5, "R2 five zeros");
    wr(16'hF872, "R2 sync A after five");
    wr(16'h4E1F, "R2 no match");
    wr(16'h1111, "R2 no Pc");

    // R5: broken DTS pair ignored
    wr(16'h7FFE, "R5 hi");
    wr(16'h0000, "R5 break");
    wr(16'h8001, "R5 no match");

    // R5/R6: DTS sync, then burst, staggered expiry
    wr(16'h7FFE, "R5 hi");
    e_dts = 1; wr(16'h8001, "R5 R6 R8 dts");
    ticks(8, "R5 hold");
    zeros(4, "R6 zeros");
    wr(16'hF872, "R6 sync A");
    e_npcm = 1; wr(16'h4E1F, "R6 sync B");
    e_pc = 16'h0085; wr(16'h0085, "R3 Pc err flag");
    e_pd = 16'h1200; wr(16'h1200, "R3 Pd");
    ticks(7, "R5 hold");
    e_dts = 0; put(1'b0, 16'h0, 1'b1, "R5 R6 R7 dts expire keeps Pc");
    ticks(7, "R4 hold");
    e_npcm = 0; put(1'b0, 16'h0, 1'b1, "R4 R7 R8 final expire");

    @(negedge clk);
    word_valid = 0; frame_tick = 0;
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule